// File: doc/BRIEF.md
# Serial Byte Receiver with Frame Realignment

This block turns an asynchronous serial line into bytes. Each frame has a low start bit, eight data bits with the least significant bit first, and a high stop bit. There is no parity and no flow control. The line passes through a short synchronizer. A single divider then produces a sampling tick at eight times the bit rate. While the receiver waits for a frame it looks at the line on every fast tick. When it sees a falling edge, it restarts the bit timer so that each later sample falls near the centre of its bit.

If the stop bit reads low, the receiver flags a framing error and enters a recovery mode. It leaves recovery in one of two ways: after ten consecutive high bit periods, or after one whole frame with correct spacing. Any byte it sees while recovering is dropped, and only frames received outside recovery produce a valid strobe. A synchronous reset returns the receiver to idle and clears recovery, so that the logic which consumes the bytes can force a realignment.

Top module: `serial_rx_resync`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rx_valid`, `frame_err` and `in_recovery` are 0, and `rx_data` is 0.
- R2: A frame received outside recovery mode with a high stop bit delivers its byte on `rx_data`, where the first data bit after the start bit is bit 0. `rx_data` holds that value until the next delivered byte.
- R3: `rx_valid` is a pulse exactly one clock wide, and there is one pulse per delivered frame.
- R4: A stop bit sampled low raises `frame_err` for exactly one clock, gives no `rx_valid`, and sets `in_recovery` to 1.
- R5: In recovery mode, a frame with a high stop bit is dropped (no `rx_valid`) and ends recovery, so the next frame is delivered.
- R6: In recovery mode, ten consecutive high bit periods end recovery. After nine such periods, `in_recovery` is still 1.
- R7: In idle, a low pulse shorter than half a bit is treated as a false start: no byte and no error.
- R8: Each start edge re-aligns the bit timer, so frames are received whatever their phase relative to the divider, including frames sent back to back.
- R9: A one-clock pulse on `rst` during recovery clears `in_recovery` at once, and the next frame is delivered without waiting for idle bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; returns the receiver to idle |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| rx_data | output | DATA_BITS | Last delivered byte |
| rx_valid | output | 1 | One-clock strobe for a newly delivered byte |
| frame_err | output | 1 | One-clock pulse when a stop bit reads low |
| in_recovery | output | 1 | High while the receiver is regaining frame alignment |

## Verification
The hardest situation to reach is leaving recovery through a correctly spaced frame rather than through the idle count. Recovery is always entered through a deliberately corrupted stop bit. The stimulus then waits only two idle bits before sending a clean frame, which keeps the idle counter far from ten. It checks that this frame is dropped and that the frame after it arrives. The ten-bit exit is bracketed by checking `in_recovery` after nine idle bit periods and again after ten. The phase of the start edge relative to the divider is swept across all 256 byte values, using varying clock offsets and gaps of zero or one idle bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_HUNT
   } rx_state_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b1;
               else     chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= 1'b1;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_ticks.sv
module serial_rx_ticks #(
   parameter int CLK_HZ = 50_000_000,
   parameter int BAUD   = 115_200,
   parameter int OS     = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic os_tick,
   output logic bit_tick
);
   localparam int DIV       = (CLK_HZ + (BAUD * OS) / 2) / (BAUD * OS);
   localparam int FW        = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int PW        = $clog2(OS);
   localparam int SAMPLE_PH = OS / 2 - 2;
   localparam bit OS_POW2   = ((OS & (OS - 1)) == 0);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("serial_rx_ticks: clock too slow for the requested rate");
      end
   endgenerate

   logic [FW-1:0] frac;
   logic [PW-1:0] phase;
   logic [PW-1:0] phase_nx;

   assign os_tick  = (frac == FW'(DIV - 1));
   assign bit_tick = os_tick && (phase == PW'(SAMPLE_PH));

   generate
      if (OS_POW2) begin : g_wrap_free
         assign phase_nx = phase + 1'b1;
      end else begin : g_wrap_cmp
         assign phase_nx = (phase == PW'(OS - 1)) ? '0 : phase + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         frac  <= '0;
         phase <= '0;
      end else if (os_tick) begin
         frac  <= '0;
         phase <= phase_nx;
      end else begin
         frac  <= frac + 1'b1;
      end
   end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int IDLE_BITS = 10
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 line,
   input  logic                 os_tick,
   input  logic                 bit_tick,
   output logic                 restart,
   output logic [DATA_BITS-1:0] data,
   output logic                 valid,
   output logic                 ferr,
   output logic                 recov
);
   localparam int BW = $clog2(DATA_BITS);
   localparam int HW = $clog2(IDLE_BITS);

   rx_state_t            state;
   logic [DATA_BITS-1:0] shreg;
   logic [BW-1:0]        bcnt;
   logic [HW-1:0]        hcnt;
   logic                 last_os;
   logic                 start_seen;

   assign start_seen = os_tick && !line && last_os;
   assign restart    = start_seen && ((state == RX_IDLE) || (state == RX_HUNT));

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= RX_IDLE;
         shreg   <= '0;
         bcnt    <= '0;
         hcnt    <= '0;
         last_os <= 1'b1;
         data    <= '0;
         valid   <= 1'b0;
         ferr    <= 1'b0;
         recov   <= 1'b0;
      end else begin
         valid <= 1'b0;
         ferr  <= 1'b0;
         if (os_tick) last_os <= line;
         case (state)
            RX_IDLE: begin
               if (start_seen) state <= RX_START;
            end
            RX_START: begin
               if (bit_tick) begin
                  if (!line) begin
                     state <= RX_DATA;
                     bcnt  <= '0;
                  end else begin
                     state <= recov ? RX_HUNT : RX_IDLE;
                  end
               end
            end
            RX_DATA: begin
               if (bit_tick) begin
                  shreg <= {line, shreg[DATA_BITS-1:1]};
                  if (bcnt == BW'(DATA_BITS - 1)) state <= RX_STOP;
                  else                            bcnt  <= bcnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (bit_tick) begin
                  if (line) begin
                     if (!recov) begin
                        data  <= shreg;
                        valid <= 1'b1;
                     end
                     recov <= 1'b0;
                     state <= RX_IDLE;
                  end else begin
                     ferr  <= 1'b1;
                     recov <= 1'b1;
                     hcnt  <= '0;
                     state <= RX_HUNT;
                  end
               end
            end
            RX_HUNT: begin
               if (start_seen) begin
                  hcnt  <= '0;
                  state <= RX_START;
               end else if (bit_tick) begin
                  if (!line) begin
                     hcnt <= '0;
                  end else if (hcnt == HW'(IDLE_BITS - 1)) begin
                     hcnt  <= '0;
                     recov <= 1'b0;
                     state <= RX_IDLE;
                  end else begin
                     hcnt <= hcnt + 1'b1;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/serial_rx_resync.sv
module serial_rx_resync #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BAUD        = 115_200,
   parameter int OS          = 8,
   parameter int DATA_BITS   = 8,
   parameter int IDLE_BITS   = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 rx_line,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 frame_err,
   output logic                 in_recovery
);
   generate
      if (OS < 4 || (OS % 2) != 0) begin : g_bad_os
         $error("serial_rx_resync: OS must be even and at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_dw
         $error("serial_rx_resync: DATA_BITS must be at least 2");
      end
      if (IDLE_BITS < 2) begin : g_bad_idle
         $error("serial_rx_resync: IDLE_BITS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_rx_resync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic line_s;
   logic os_tick;
   logic bit_tick;
   logic restart;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d_in  (rx_line),
      .q_out (line_s)
   );

   serial_rx_ticks #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OS(OS)) u_ticks (
      .clk      (clk),
      .rst      (rst),
      .restart  (restart),
      .os_tick  (os_tick),
      .bit_tick (bit_tick)
   );

   serial_rx_frame #(.DATA_BITS(DATA_BITS), .IDLE_BITS(IDLE_BITS)) u_frame (
      .clk      (clk),
      .rst      (rst),
      .line     (line_s),
      .os_tick  (os_tick),
      .bit_tick (bit_tick),
      .restart  (restart),
      .data     (rx_data),
      .valid    (rx_valid),
      .ferr     (frame_err),
      .recov    (in_recovery)
   );
endmodule

// File: rtl/serial_rx_resync_chk.sv
module serial_rx_resync_chk #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 rx_valid,
   input logic                 frame_err,
   input logic                 in_recovery
);
   // R1 / R9: first cycle after reset is fully quiet
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rx_valid && !frame_err && !in_recovery && rx_data == '0));

   // R2: delivered byte holds between strobes
   a_r2_data_holds: assert property (@(posedge clk) disable iff (rst)
      (!rx_valid && !$past(rst)) |-> $stable(rx_data));

   // R3: strobe is one clock wide
   a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   // R4: error pulse is one clock, never with a byte, and enters recovery
   a_r4_err_single: assert property (@(posedge clk) disable iff (rst)
      frame_err |=> !frame_err);
   a_r4_err_no_valid: assert property (@(posedge clk) disable iff (rst)
      frame_err |-> !rx_valid);
   a_r4_err_recovery: assert property (@(posedge clk) disable iff (rst)
      frame_err |-> in_recovery);

   // R5: no byte is delivered out of recovery mode
   a_r5_no_valid_from_recovery: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> !$past(in_recovery));
endmodule

bind serial_rx_resync serial_rx_resync_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .rx_data     (rx_data),
   .rx_valid    (rx_valid),
   .frame_err   (frame_err),
   .in_recovery (in_recovery)
);

// File: tb/serial_rx_resync_tb.sv
module serial_rx_resync_tb;
   localparam int CLK_HZ   = 32;
   localparam int BAUD     = 1;
   localparam int BIT_CLKS = CLK_HZ / BAUD;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_line = 1'b1;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       frame_err;
   logic       in_recovery;

   int nchk = 0;
   int nfail = 0;
   int vcnt = 0;
   int ecnt = 0;
   int wide_v = 0;
   int wide_e = 0;
   int last_byte = 0;
   bit prev_v = 1'b0;
   bit prev_e = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   serial_rx_resync #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .rx_line     (rx_line),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid),
      .frame_err   (frame_err),
      .in_recovery (in_recovery)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (rx_valid) begin
            vcnt++;
            last_byte = int'(rx_data);
            if (prev_v) wide_v++;
         end
         if (frame_err) begin
            ecnt++;
            if (prev_e) wide_e++;
         end
         prev_v = rx_valid;
         prev_e = frame_err;
      end else begin
         prev_v = 1'b0;
         prev_e = 1'b0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_bits(input int n);
      rx_line = 1'b1;
      wait_clks(n * BIT_CLKS);
   endtask

   task automatic send(input logic [7:0] b, input bit stop);
      rx_line = 1'b0;
      wait_clks(BIT_CLKS);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         wait_clks(BIT_CLKS);
      end
      rx_line = stop;
      wait_clks(BIT_CLKS);
      rx_line = 1'b1;
   endtask

   initial begin
      int v0;
      int e0;
      wait_clks(5);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check("R1 valid", int'(rx_valid), 0);
      check("R1 err", int'(frame_err), 0);
      check("R1 recovery", int'(in_recovery), 0);
      check("R1 data", int'(rx_data), 0);

      // R2: basic byte, LSB first
      idle_bits(2);
      send(8'hA5, 1'b1);
      check("R2 count", vcnt, 1);
      check("R2 data", last_byte, 8'hA5);

      // R7: short low glitch in idle
      v0 = vcnt; e0 = ecnt;
      rx_line = 1'b0;
      wait_clks(BIT_CLKS / 4);
      idle_bits(2);
      check("R7 no byte", vcnt, v0);
      check("R7 no error", ecnt, e0);
      send(8'h0F, 1'b1);
      check("R7 next byte", last_byte, 8'h0F);

      // R4: bad stop bit
      v0 = vcnt; e0 = ecnt;
      send(8'h3C, 1'b0);
      check("R4 error count", ecnt, e0 + 1);
      check("R4 no byte", vcnt, v0);
      check("R4 recovery", int'(in_recovery), 1);

      // R6: ten idle bits end recovery
      idle_bits(9);
      check("R6 still recovering", int'(in_recovery), 1);
      idle_bits(1);
      check("R6 recovered", int'(in_recovery), 0);
      send(8'h5A, 1'b1);
      check("R6 byte after idle", vcnt, v0 + 1);
      check("R6 data", last_byte, 8'h5A);

      // R5: clean frame during recovery is dropped and ends recovery
      v0 = vcnt;
      send(8'h11, 1'b0);
      idle_bits(2);
      check("R5 recovering", int'(in_recovery), 1);
      send(8'h22, 1'b1);
      check("R5 dropped", vcnt, v0);
      check("R5 recovery ended", int'(in_recovery), 0);
      send(8'h33, 1'b1);
      check("R5 next count", vcnt, v0 + 1);
      check("R5 next data", last_byte, 8'h33);

      // R9: reset during recovery
      v0 = vcnt;
      send(8'h44, 1'b0);
      check("R9 recovering", int'(in_recovery), 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R9 recovery cleared", int'(in_recovery), 0);
      check("R9 data cleared", int'(rx_data), 0);
      idle_bits(1);
      send(8'h55, 1'b1);
      check("R9 byte count", vcnt, v0 + 1);
      check("R9 data", last_byte, 8'h55);

      // R8 / R2: all bytes, varying phase and gaps
      e0 = ecnt;
      for (int b = 0; b < 256; b++) begin
         v0 = vcnt;
         wait_clks(b % 7);
         if (b % 3 != 0) idle_bits(1);
         send(8'(b), 1'b1);
         check("R8 count", vcnt, v0 + 1);
         check("R2 sweep data", last_byte, b);
      end
      check("R8 no errors", ecnt, e0);

      // R3 / R4: pulse widths
      check("R3 valid width", wide_v, 0);
      check("R4 error width", wide_e, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      wait_clks(190_000);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule